// File: doc/BRIEF.md
# Descriptor-Chained Selector Channel

This block is a byte-wide selector channel that moves one block of bytes between one attached device and a 16-bit word memory, with no processor involvement once it has started. Software prepares a pointer table in memory with two words per slot: a pointer word and an order word. It then pulses `start` with a slot number, a transfer direction and an interrupt-arm flag. The channel reads the slot's pointer and sends the order byte to the device. It then works through a list of two-word descriptors. Each descriptor gives a byte count and a starting byte address, and bytes are packed into the left or right half of each memory word.

Descriptors can chain to the next descriptor in the list, so scattered buffers form one device stream. A link descriptor can also send the channel to a fresh list through a new pointer. When the last descriptor is exhausted, the channel marks the slot's pointer word as finished. It then goes idle and gives a one-cycle interrupt pulse if the run was armed. If the channel meets a pointer that is already marked finished, it stops with an error flag instead.

The device side has two valid/ready byte streams. On the outgoing stream the channel is the source: it holds `dev_out_valid` and the byte steady until the cycle in which `dev_out_ready` is high, and that cycle completes the transfer. On the incoming stream the channel is the sink: it raises `dev_in_ready` only while it can take a byte, and a byte is taken in a cycle with both `dev_in_valid` and `dev_in_ready` high. The memory port is a plain request/grant port. An access completes in the cycle in which `mem_gnt` is high, and read data is taken in that same cycle.

Top module: `selchan_dma`

## Requirements
- R1: While idle, a `start` pulse captures `start_slot`, `start_dir_in` and `start_arm`, and `busy` is high from the next cycle until the run ends. A `start` pulse while busy is ignored.
- R2: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady. An access completes in the cycle that `mem_gnt` is high.
- R3: The pointer for slot s is the word at PTR_BASE+2s. Its bit 15 is the finished flag and bits 14:0 hold half the word address of the first descriptor, so the list starts at word 2×(bits 14:0).
- R4: Before any data byte, the low byte of the word at PTR_BASE+2s+1 is presented once on the outgoing stream with `dev_out_order` high, whatever the direction. Data bytes carry `dev_out_order` low.
- R5: In descriptor word 0, bit 15 is the chain flag, bit 14 is the link flag and bits 13:0 are the byte count. Descriptor word 1 is a byte address whose word address is the byte address shifted right by one. Byte address bit 0 = 0 selects bits 15:8 and bit 0 = 1 selects bits 7:0.
- R6: In the output direction (`start_dir_in` = 0), the bytes of a descriptor go out in ascending byte-address order. Each byte is held steady while `dev_out_ready` is low.
- R7: In the input direction (`start_dir_in` = 1), each accepted byte is written into its addressed half-word by reading and then writing the containing word, and the other half keeps its old value. No word outside the described range changes.
- R8: When a descriptor's count runs out and its chain flag is 1 (link flag 0), the next descriptor two words further on is fetched and the device stream continues without a new order byte.
- R9: A descriptor with both flags set is a link: its word 1 is a new pointer and the list continues at twice its bits 14:0. If any pointer the channel fetches (table or link) has bit 15 set, the run stops with `err` high, no finished-flag write and no interrupt. `err` clears at the next accepted start.
- R10: After the last byte of a descriptor whose chain flag is 0, the channel writes the slot's pointer word with bit 15 set and bits 14:0 as originally read. `busy` then falls, and `irq` pulses for exactly one cycle if and only if the run was armed.
- R11: A data descriptor with a count of zero moves no bytes and is treated as already exhausted: it chains or finishes according to its chain flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_slot | input | SLOT_W | Pointer-table slot for the run |
| start_dir_in | input | 1 | 1 = device to memory, 0 = memory to device |
| start_arm | input | 1 | Arm the completion interrupt |
| busy | output | 1 | Run in progress |
| err | output | 1 | Last run stopped on a finished pointer |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with grant |
| mem_gnt | input | 1 | Access completes this cycle |
| dev_out_valid | output | 1 | Outgoing byte valid |
| dev_out_ready | input | 1 | Device takes the outgoing byte |
| dev_out_data | output | 8 | Outgoing byte |
| dev_out_order | output | 1 | Outgoing byte is the order byte |
| dev_in_valid | input | 1 | Incoming byte valid |
| dev_in_ready | output | 1 | Channel can take an incoming byte |
| dev_in_data | input | 8 | Incoming byte |

## Verification
The bench builds the channel with PTR_BASE = 0x0020 and SLOT_W = 2. This gives four table slots that sit with their lists and buffers inside a 1024-word model memory. Grant latencies of zero and two cycles, together with a stalling device pattern, exercise the hold rules on both the memory port and the streams. These settings let the bench reach odd and even starting halves, chained lists with empty descriptors, link redirection, and finished-pointer errors, each within a few hundred cycles.

// File: rtl/selchan_pkg.sv
package selchan_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = WORD_W - 2;
  localparam int FLD_W  = WORD_W - 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PTR, ST_ORD, ST_ORDOUT, ST_D0, ST_D1,
    ST_RD, ST_OUT, ST_IN, ST_WR, ST_CE
  } chan_st_e;
endpackage

// File: rtl/selchan_desc.sv
module selchan_desc
  import selchan_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  output logic              d_chain,
  output logic              d_link,
  output logic [CNT_W-1:0]  d_cnt,
  output logic              d_zero,
  output logic              d_link_ce,
  output logic [WORD_W-1:0] d_link_list
);
  // word 0: flag pair on top, count below
  assign d_link      = w0[WORD_W-1] & w0[WORD_W-2];
  assign d_chain     = w0[WORD_W-1] & ~w0[WORD_W-2];
  assign d_cnt       = w0[CNT_W-1:0];
  assign d_zero      = (d_cnt == '0);
  // link payload is a pointer: finished flag on top, halved list address below
  assign d_link_ce   = w1[WORD_W-1];
  assign d_link_list = {w1[FLD_W-1:0], 1'b0};
endmodule

// File: rtl/selchan_lane.sv
module selchan_lane
  import selchan_pkg::*;
#(
  parameter int LANES = WORD_W / BYTE_W,
  parameter int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] word_rd,
  input  logic [WORD_W-1:0] word_mod,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic [WORD_W-1:0] word_out
);
  logic [LANES-1:0] hit;

  // lowest byte address maps to the most significant lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = (SEL_W'(LANES - 1 - g) == sel);
    assign word_out[g*BYTE_W +: BYTE_W] = hit[g] ? byte_in : word_mod[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < LANES; i++)
      if (hit[i]) byte_out = word_rd[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/selchan_ctl.sv
module selchan_ctl
  import selchan_pkg::*;
#(
  parameter logic [WORD_W-1:0] PTR_BASE = 16'h0010,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic              start_dir_in,
  input  logic              start_arm,
  output logic              busy,
  output logic              err,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_gnt,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [BYTE_W-1:0] dev_out_data,
  output logic              dev_out_order,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [BYTE_W-1:0] dev_in_data,
  output logic [WORD_W-1:0] w0,
  input  logic              d_chain,
  input  logic              d_link,
  input  logic [CNT_W-1:0]  d_cnt,
  input  logic              d_zero,
  input  logic              d_link_ce,
  input  logic [WORD_W-1:0] d_link_list,
  output logic              sel,
  output logic [WORD_W-1:0] word_mod,
  output logic [BYTE_W-1:0] byte_mod,
  input  logic [BYTE_W-1:0] lane_byte,
  input  logic [WORD_W-1:0] lane_word
);
  chan_st_e          st;
  logic [SLOT_W-1:0] slot_q;
  logic              dir_in_q, arm_q, err_q, irq_q;
  logic [FLD_W-1:0]  tptr_q;
  logic [WORD_W-1:0] dptr_q, w0_q, badr_q, word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] byte_q;
  logic [WORD_W-1:0] ptr_addr;
  logic              step;

  assign ptr_addr = PTR_BASE + WORD_W'({slot_q, 1'b0});
  assign step     = (st == ST_OUT && dev_out_ready) || (st == ST_WR && mem_gnt);

  assign w0       = w0_q;
  assign sel      = badr_q[0];
  assign word_mod = word_q;
  assign byte_mod = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      slot_q   <= '0;
      dir_in_q <= 1'b0;
      arm_q    <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      tptr_q   <= '0;
      dptr_q   <= '0;
      w0_q     <= '0;
      badr_q   <= '0;
      word_q   <= '0;
      cnt_q    <= '0;
      byte_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          slot_q   <= start_slot;
          dir_in_q <= start_dir_in;
          arm_q    <= start_arm;
          err_q    <= 1'b0;
          st       <= ST_PTR;
        end
        ST_PTR: if (mem_gnt) begin
          if (mem_rdata[WORD_W-1]) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            tptr_q <= mem_rdata[FLD_W-1:0];
            dptr_q <= {mem_rdata[FLD_W-1:0], 1'b0};
            st     <= ST_ORD;
          end
        end
        ST_ORD: if (mem_gnt) begin
          byte_q <= mem_rdata[BYTE_W-1:0];
          st     <= ST_ORDOUT;
        end
        ST_ORDOUT: if (dev_out_ready) st <= ST_D0;
        ST_D0: if (mem_gnt) begin
          w0_q <= mem_rdata;
          st   <= ST_D1;
        end
        ST_D1: if (mem_gnt) begin
          if (d_link) begin
            if (d_link_ce) begin
              err_q <= 1'b1;
              st    <= ST_IDLE;
            end else begin
              dptr_q <= d_link_list;
              st     <= ST_D0;
            end
          end else begin
            cnt_q  <= d_cnt;
            badr_q <= mem_rdata;
            if (d_zero) begin
              if (d_chain) begin
                dptr_q <= dptr_q + WORD_W'(2);
                st     <= ST_D0;
              end else begin
                st <= ST_CE;
              end
            end else begin
              st <= dir_in_q ? ST_IN : ST_RD;
            end
          end
        end
        ST_IN: if (dev_in_valid) begin
          byte_q <= dev_in_data;
          st     <= ST_RD;
        end
        ST_RD: if (mem_gnt) begin
          word_q <= mem_rdata;
          if (dir_in_q) begin
            st <= ST_WR;
          end else begin
            byte_q <= lane_byte;
            st     <= ST_OUT;
          end
        end
        ST_CE: if (mem_gnt) begin
          irq_q <= arm_q;
          st    <= ST_IDLE;
        end
        default: ;
      endcase
      if (step) begin
        badr_q <= badr_q + WORD_W'(1);
        cnt_q  <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          if (d_chain) begin
            dptr_q <= dptr_q + WORD_W'(2);
            st     <= ST_D0;
          end else begin
            st <= ST_CE;
          end
        end else begin
          st <= dir_in_q ? ST_IN : ST_RD;
        end
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_addr;
    mem_wdata = '0;
    case (st)
      ST_PTR: mem_req = 1'b1;
      ST_ORD: begin mem_req = 1'b1; mem_addr = ptr_addr + WORD_W'(1); end
      ST_D0:  begin mem_req = 1'b1; mem_addr = dptr_q; end
      ST_D1:  begin mem_req = 1'b1; mem_addr = dptr_q + WORD_W'(1); end
      ST_RD:  begin mem_req = 1'b1; mem_addr = {1'b0, badr_q[WORD_W-1:1]}; end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {1'b0, badr_q[WORD_W-1:1]};
        mem_wdata = lane_word;
      end
      ST_CE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {1'b1, tptr_q};
      end
      default: ;
    endcase
  end

  assign busy          = (st != ST_IDLE);
  assign err           = err_q;
  assign irq           = irq_q;
  assign dev_out_valid = (st == ST_ORDOUT) || (st == ST_OUT);
  assign dev_out_order = (st == ST_ORDOUT);
  assign dev_out_data  = byte_q;
  assign dev_in_ready  = (st == ST_IN);

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data) && $stable(dev_out_order));
  assert_one_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_out_valid && dev_in_ready));
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !irq && !(mem_req && mem_we && !busy));
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(busy));
endmodule

// File: rtl/selchan_dma.sv
module selchan_dma
  import selchan_pkg::*;
#(
  parameter logic [15:0] PTR_BASE = 16'h0010,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic              start_dir_in,
  input  logic              start_arm,
  output logic              busy,
  output logic              err,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [15:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_gnt,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [7:0]        dev_out_data,
  output logic              dev_out_order,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [7:0]        dev_in_data
);
  logic [WORD_W-1:0] w0, d_link_list, word_mod, lane_word;
  logic              d_chain, d_link, d_zero, d_link_ce, sel;
  logic [CNT_W-1:0]  d_cnt;
  logic [BYTE_W-1:0] byte_mod, lane_byte;

  selchan_desc u_desc (
    .w0(w0), .w1(mem_rdata), .d_chain(d_chain), .d_link(d_link), .d_cnt(d_cnt),
    .d_zero(d_zero), .d_link_ce(d_link_ce), .d_link_list(d_link_list)
  );

  selchan_lane u_lane (
    .sel(sel), .word_rd(mem_rdata), .word_mod(word_mod), .byte_in(byte_mod),
    .byte_out(lane_byte), .word_out(lane_word)
  );

  selchan_ctl #(.PTR_BASE(PTR_BASE), .SLOT_W(SLOT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_slot(start_slot),
    .start_dir_in(start_dir_in), .start_arm(start_arm), .busy(busy), .err(err), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .dev_out_order(dev_out_order), .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .w0(w0), .d_chain(d_chain), .d_link(d_link), .d_cnt(d_cnt),
    .d_zero(d_zero), .d_link_ce(d_link_ce), .d_link_list(d_link_list), .sel(sel),
    .word_mod(word_mod), .byte_mod(byte_mod), .lane_byte(lane_byte), .lane_word(lane_word)
  );
endmodule

// File: tb/selchan_dma_test.sv
`timescale 1ns/1ps
module selchan_dma_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_dir_in = 1'b0, start_arm = 1'b0;
  logic [1:0] start_slot = '0;
  logic busy, err, irq, mem_req, mem_we, mem_gnt = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic dev_out_valid, dev_out_ready = 1'b1, dev_out_order, dev_in_valid = 1'b0, dev_in_ready;
  logic [7:0] dev_out_data, dev_in_data = '0;

  logic [15:0] mem [0:1023];
  logic [7:0]  out_b [0:63];
  logic        out_o [0:63];
  logic [7:0]  in_q [0:15];
  int out_n = 0, irq_n = 0, in_idx = 0, in_lim = 0;
  int gnt_delay = 0, ready_mode = 0, wcnt = 0, viol = 0, stall = 0;
  logic [15:0] hold_addr;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  selchan_dma #(.PTR_BASE(16'h0020), .SLOT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_slot(start_slot),
    .start_dir_in(start_dir_in), .start_arm(start_arm), .busy(busy), .err(err), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data), .dev_out_order(dev_out_order),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  // memory model: grant after gnt_delay waiting cycles, write at grant
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0; wcnt = 0;
    end else if (mem_gnt) begin
      mem_gnt = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == 0) hold_addr = mem_addr;
      else if (mem_addr != hold_addr) viol++;
      if (wcnt >= gnt_delay) begin
        mem_gnt = 1'b1;
        if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
      end
      wcnt++;
    end
  end

  // device model: both streams, optional stalls
  always @(negedge clk) begin
    stall++;
    dev_out_ready = (ready_mode == 0) || (stall % 3 == 0);
    if (dev_out_valid && dev_out_ready && out_n < 64) begin
      out_b[out_n] = dev_out_data; out_o[out_n] = dev_out_order; out_n++;
    end
    if (irq) irq_n++;
    dev_in_valid = (in_idx < in_lim) && ((ready_mode == 0) || (stall % 2 == 0));
    dev_in_data  = in_q[in_idx % 16];
    if (dev_in_valid && dev_in_ready) in_idx++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic go(input logic [1:0] s, input logic din, input logic arm);
    @(negedge clk);
    start = 1'b1; start_slot = s; start_dir_in = din; start_arm = arm;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    check("idle timeout", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bytes(input string tag, input int base, input int n,
                             input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0] e [0:3];
    e[0] = b0; e[1] = b1; e[2] = b2; e[3] = b3;
    check({tag, " count"}, out_n - base, n);
    for (int i = 0; i < n && i < 4; i++) begin
      check({tag, " byte"}, {24'd0, out_b[base+i]}, {24'd0, e[i]});
      check({tag, " order flag"}, {31'd0, out_o[base+i]}, {31'd0, i == 0});
    end
  endtask

  task automatic t_reset();
    check("R1 reset busy", {31'd0, busy}, 0);
    check("R1 reset irq/err", {30'd0, irq, err}, 0);
    check("R2 reset req", {31'd0, mem_req}, 0);
    check("R6 reset streams", {30'd0, dev_out_valid, dev_in_ready}, 0);
  endtask

  // R3 R4 R5 R6 R10: single descriptor, odd first byte, armed
  task automatic t_simple_out();
    int b = out_n, q = irq_n;
    mem['h22] = 16'h0040; mem['h23] = 16'h00A5;
    mem['h80] = 16'h0003; mem['h81] = 16'h0201;
    mem['h100] = 16'h1122; mem['h101] = 16'h3344;
    gnt_delay = 0; ready_mode = 0;
    go(2'd1, 1'b0, 1'b1);
    check("R1 busy after start", {31'd0, busy}, 1);
    wait_idle();
    check_bytes("R4 R5 R6 simple", b, 4, 8'hA5, 8'h22, 8'h33, 8'h44);
    check("R10 finished flag", {16'd0, mem['h22]}, 32'h8040);
    check("R10 irq once armed", irq_n - q, 1);
    check("R9 err clear", {31'd0, err}, 0);
  endtask

  // R8 R11: chain through an empty descriptor, stalls, not armed
  task automatic t_chain_out();
    int b = out_n, q = irq_n;
    mem['h24] = 16'h0050; mem['h25] = 16'h0000;
    mem['hA0] = 16'h8002; mem['hA1] = 16'h0220;
    mem['hA2] = 16'h8000; mem['hA3] = 16'h0300;
    mem['hA4] = 16'h0001; mem['hA5] = 16'h0231;
    mem['h110] = 16'hAABB; mem['h118] = 16'h77CC;
    gnt_delay = 1; ready_mode = 1;
    go(2'd2, 1'b0, 1'b0);
    wait_idle();
    check_bytes("R8 R11 chain", b, 4, 8'h00, 8'hAA, 8'hBB, 8'hCC);
    check("R10 no irq unarmed", irq_n - q, 0);
    check("R10 finished flag chain", {16'd0, mem['h24]}, 32'h8050);
  endtask

  // R7: input direction, read-modify-write, grant delay
  task automatic t_input();
    int b = out_n, q = irq_n;
    mem['h26] = 16'h0060; mem['h27] = 16'h0011;
    mem['hC0] = 16'h0003; mem['hC1] = 16'h0241;
    mem['h120] = 16'h5A5A; mem['h121] = 16'h6B6B; mem['h122] = 16'h7C7C;
    in_q[in_lim % 16] = 8'hD1; in_q[(in_lim+1) % 16] = 8'hD2; in_q[(in_lim+2) % 16] = 8'hD3;
    in_lim = in_lim + 3;
    gnt_delay = 2; ready_mode = 1;
    go(2'd3, 1'b1, 1'b1);
    wait_idle();
    check("R4 order only on input", out_n - b, 1);
    check("R4 order byte input", {24'd0, out_b[b]}, 32'h11);
    check("R7 right half kept left", {16'd0, mem['h120]}, 32'h5AD1);
    check("R7 full word", {16'd0, mem['h121]}, 32'hD2D3);
    check("R7 beyond range", {16'd0, mem['h122]}, 32'h7C7C);
    check("R7 bytes consumed", in_idx, in_lim);
    check("R10 irq input", irq_n - q, 1);
  endtask

  // R9: link to a fresh list
  task automatic t_link();
    int b = out_n, q = irq_n;
    mem['h20] = 16'h0070; mem['h21] = 16'h0005;
    mem['hE0] = 16'hC000; mem['hE1] = 16'h0078;
    mem['hF0] = 16'h0002; mem['hF1] = 16'h0300;
    mem['h180] = 16'h9182;
    gnt_delay = 0; ready_mode = 0;
    go(2'd0, 1'b0, 1'b1);
    wait_idle();
    check_bytes("R9 link", b, 3, 8'h05, 8'h91, 8'h82, 8'h00);
    check("R9 table flag after link", {16'd0, mem['h20]}, 32'h8070);
    check("R10 irq link", irq_n - q, 1);
  endtask

  // R9: link naming a finished pointer
  task automatic t_link_err();
    int b = out_n, q = irq_n;
    mem['h22] = 16'h0040; mem['h23] = 16'h00A5;
    mem['h80] = 16'hC000; mem['h81] = 16'h8078;
    go(2'd1, 1'b0, 1'b1);
    wait_idle();
    check("R9 err on finished link", {31'd0, err}, 1);
    check("R9 no flag write", {16'd0, mem['h22]}, 32'h0040);
    check("R9 no irq on err", irq_n - q, 0);
    check("R9 only order out", out_n - b, 1);
  endtask

  // R9: table pointer already finished
  task automatic t_table_err();
    int b = out_n, q = irq_n;
    mem['h24] = 16'h8050;
    go(2'd2, 1'b0, 1'b1);
    wait_idle();
    check("R9 err on finished table", {31'd0, err}, 1);
    check("R9 nothing out", out_n - b, 0);
    check("R9 no irq", irq_n - q, 0);
  endtask

  // R1: start while busy is ignored, err cleared by start
  task automatic t_busy_start();
    int b = out_n, q = irq_n;
    mem['h20] = 16'h0070; mem['h26] = 16'h0060;
    gnt_delay = 1;
    go(2'd0, 1'b0, 1'b1);
    check("R9 err cleared at start", {31'd0, err}, 0);
    repeat (4) @(negedge clk);
    go(2'd3, 1'b0, 1'b1);
    wait_idle();
    check_bytes("R1 first run only", b, 3, 8'h05, 8'h91, 8'h82, 8'h00);
    check("R1 second slot untouched", {16'd0, mem['h26]}, 32'h0060);
    check("R1 single irq", irq_n - q, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_simple_out();
    t_chain_out();
    t_input();
    t_link();
    t_link_err();
    t_table_err();
    t_busy_start();
    check("R2 address held while waiting", viol, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule